// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of scatter-gather segments into a table of physical region descriptors that a bus-mastering DMA engine can walk. Each segment is a 32-bit bus address and a byte length. Each descriptor is two 32-bit words. The first word is a start address and the second word is a byte count plus flags. Segments arrive over a valid/ready handshake, and a last flag closes the stream. Descriptor words leave through a plain memory write port that carries a word index, data and a write strobe.

The builder cuts each segment so that no descriptor crosses a 64 KiB address boundary. Some hosts decode a 16-bit count of zero as zero bytes, so in the standard format a piece of exactly 64 KiB is written as two 32 KiB descriptors. A table that would grow past the configured capacity is abandoned. The same happens to a stream that carries no bytes. In both cases the caller is told to move the data with programmed I/O instead. A mode input selects an alternate count layout: a word-granular count in the upper half of the second word, with no end marker.

Top module: `sg_prd_builder`

## Requirements
- R1: No descriptor crosses a 64 KiB address boundary. The first piece of a segment is the smaller of (0x10000 minus the low 16 bits of the address) and the bytes left. Each later piece starts where the previous one ended.
- R2: Descriptor k occupies word index 2k (the start address) and word index 2k+1 (the count word). In the standard format the byte count sits in bits 15:0 of the count word.
- R3: In the standard format, a piece of exactly 0x10000 bytes becomes two descriptors with count 0x8000. The first starts at the piece address and the second at that address plus 0x8000.
- R4: In the standard format, bit 31 of the count word of the final descriptor is set. No other count word has bit 31 set.
- R5: If a descriptor would be the (MAX_DESC+1)-th, including the second half of a split, the build aborts. `done` then comes with `fallback`=1 and `entry_count`=0.
- R6: A stream whose segments all have length zero writes nothing. It ends with `fallback`=1 and `entry_count`=0.
- R7: With `mode_alt`=1 captured at start, bits 31:16 of the count word hold bytes/4 − 1 and bits 15:0 are zero. No end marker is written, and a 64 KiB piece stays a single descriptor.
- R8: At most one table word is written per cycle. The address word of a descriptor is followed in the next cycle by its count word. `seg_ready` is low in every cycle with a table write.
- R9: `done` is a one-cycle pulse. `entry_count`, `fallback` and `len_err` change only with `done` or on the cycle after an accepted `start`, which clears them to zero.
- R10: A non-zero length with bit 0 set (standard format), or with bits 1:0 not zero (alternate format), writes no descriptor. It sets `len_err` and `fallback` at `done`. The rest of the stream is accepted and discarded up to its last segment.
- R11: A table of exactly MAX_DESC descriptors completes with `fallback`=0 and `entry_count`=MAX_DESC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a build; sampled only while idle |
| mode_alt | input | 1 | Count format for the build, captured with start |
| seg_valid | input | 1 | Segment fields are valid |
| seg_ready | output | 1 | Builder accepts a segment this cycle |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the stream |
| tbl_we | output | 1 | Table word write strobe |
| tbl_addr | output | AW | Table word index |
| tbl_data | output | 32 | Table word value |
| done | output | 1 | One-cycle completion pulse |
| entry_count | output | CW | Descriptors in the finished table, zero on fallback |
| fallback | output | 1 | Table unusable; use programmed I/O |
| len_err | output | 1 | A segment length had the wrong alignment |

## Verification
The assertions assume that `start` is only pulsed while no build is running, and that segment fields stay constant while `seg_valid` waits for `seg_ready`. They also assume that segment addresses are even in the standard format and multiples of four in the alternate format. Under these assumptions every cut piece keeps the alignment and the count words stay well formed. The bench pulses `start` only after it has seen `done`. It holds each segment steady until the handshake completes, and every address it uses is a multiple of 0x100.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEG,
      ST_W0,
      ST_W1,
      ST_MARK,
      ST_DRAIN,
      ST_DONE
   } sgp_state_e;

   // Size of the address window a descriptor must stay inside
   localparam logic [16:0] WIN_BYTES  = 17'h10000;
   // Half window used when a full-window piece is split
   localparam logic [31:0] HALF_BYTES = 32'h0000_8000;
   // End-of-table flag in the count word
   localparam logic [31:0] EOT_FLAG   = 32'h8000_0000;

endpackage

// File: rtl/sgp_piece_calc.sv
// Size of the next piece of the current segment, limited by the 64 KiB window (R1)
module sgp_piece_calc
   import sgp_pkg::*;
#(
   parameter int LEN_W = 32
) (
   input  logic [15:0]      addr_lo,
   input  logic [LEN_W-1:0] rem,
   output logic [16:0]      piece,
   output logic             is_final
);

   logic [16:0] room;
   logic        fits;

   always_comb begin
      room     = WIN_BYTES - {1'b0, addr_lo};
      fits     = (rem <= LEN_W'(room));
      piece    = fits ? rem[16:0] : room;
      is_final = fits;
   end

endmodule

// File: rtl/sgp_word_fmt.sv
// Count-word formatting and length alignment check for the two formats
module sgp_word_fmt
   import sgp_pkg::*;
#(
   parameter bit ALT_EN = 1'b1
) (
   input  logic        alt_req,
   input  logic [16:0] piece,
   input  logic [1:0]  len_lo,
   output logic [31:0] w1,
   output logic        split_need,
   output logic        bad_len
);

   logic        alt_eff;
   logic [15:0] alt_cnt;

   generate
      if (ALT_EN) begin : g_alt
         assign alt_eff = alt_req;
      end else begin : g_std_only
         logic unused_alt;
         assign unused_alt = alt_req;
         assign alt_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      alt_cnt    = {1'b0, piece[16:2]} - 16'd1;
      // R3: a full-window piece is split only in the standard format
      split_need = !alt_eff && (piece == WIN_BYTES);
      // R10: alignment demanded by the selected format
      bad_len    = alt_eff ? (len_lo != 2'b00) : len_lo[0];
      if (alt_eff)
         w1 = {alt_cnt, 16'h0000};          // R7
      else if (split_need)
         w1 = HALF_BYTES;                   // R3
      else
         w1 = {16'h0000, piece[15:0]};      // R2
   end

endmodule

// File: rtl/sgp_ctrl.sv
// Sequencer: accepts segments, emits descriptor words, finishes the table
module sgp_ctrl
   import sgp_pkg::*;
#(
   parameter int MAX_DESC = 8,
   parameter int LEN_W    = 32,
   parameter int AW       = 4,
   parameter int CW       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mode_alt,
   input  logic             seg_valid,
   input  logic [31:0]      seg_addr,
   input  logic [LEN_W-1:0] seg_len,
   input  logic             seg_last,
   input  logic [16:0]      piece,
   input  logic             is_final,
   input  logic [31:0]      w1,
   input  logic             split_need,
   input  logic             bad_len,
   output logic             seg_ready,
   output logic [15:0]      cur_addr_lo,
   output logic [LEN_W-1:0] cur_rem,
   output logic             mode_q,
   output logic             tbl_we,
   output logic [AW-1:0]    tbl_addr,
   output logic [31:0]      tbl_data,
   output logic             done,
   output logic [CW-1:0]    entry_count,
   output logic             fallback,
   output logic             len_err
);

   localparam logic [CW-1:0] CAP = CW'(MAX_DESC);

   sgp_state_e    state;
   logic [31:0]   cur_addr;
   logic          cur_last;
   logic          half;
   logic          err_q;
   logic [CW-1:0] cnt;
   logic [31:0]   last_w1;
   logic [CW-1:0] cnt_o;
   logic          fb_o;
   logic          err_o;
   logic          full;

   assign full        = (cnt == CAP);
   assign cur_addr_lo = cur_addr[15:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode_q   <= 1'b0;
         cur_addr <= '0;
         cur_rem  <= '0;
         cur_last <= 1'b0;
         half     <= 1'b0;
         err_q    <= 1'b0;
         cnt      <= '0;
         last_w1  <= '0;
         cnt_o    <= '0;
         fb_o     <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  // R9: results are cleared when a new build begins
                  state  <= ST_SEG;
                  mode_q <= mode_alt;
                  cnt    <= '0;
                  half   <= 1'b0;
                  err_q  <= 1'b0;
                  cnt_o  <= '0;
                  fb_o   <= 1'b0;
                  err_o  <= 1'b0;
               end
            end
            ST_SEG: begin
               if (seg_valid) begin
                  if (seg_len == '0) begin
                     // R6: empty segments add nothing
                     if (seg_last) state <= ST_MARK;
                  end else if (bad_len) begin
                     // R10: misaligned length poisons the build
                     err_q <= 1'b1;
                     if (seg_last) begin
                        state <= ST_DONE;
                        fb_o  <= 1'b1;
                        err_o <= 1'b1;
                     end else begin
                        state <= ST_DRAIN;
                     end
                  end else begin
                     cur_addr <= seg_addr;
                     cur_rem  <= seg_len;
                     cur_last <= seg_last;
                     state    <= ST_W0;
                  end
               end
            end
            ST_W0: begin
               if (full) begin
                  // R5: capacity reached, abandon the table
                  fb_o  <= 1'b1;
                  err_o <= err_q;
                  state <= cur_last ? ST_DONE : ST_DRAIN;
               end else begin
                  cnt   <= cnt + CW'(1);
                  state <= ST_W1;
               end
            end
            ST_W1: begin
               last_w1 <= w1;
               if (split_need && !half) begin
                  half  <= 1'b1;
                  state <= ST_W0;
               end else begin
                  half     <= 1'b0;
                  cur_addr <= cur_addr + {15'd0, piece};
                  cur_rem  <= cur_rem - LEN_W'(piece);
                  if (is_final)
                     state <= cur_last ? ST_MARK : ST_SEG;
                  else
                     state <= ST_W0;
               end
            end
            ST_MARK: begin
               state <= ST_DONE;
               if (cnt == '0)
                  fb_o <= 1'b1;
               else
                  cnt_o <= cnt;
            end
            ST_DRAIN: begin
               if (seg_valid && seg_last) begin
                  state <= ST_DONE;
                  fb_o  <= 1'b1;
                  err_o <= err_q;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Table write port, one word per state (R8)
   always_comb begin
      tbl_we   = 1'b0;
      tbl_addr = '0;
      tbl_data = '0;
      unique case (state)
         ST_W0: begin
            tbl_we   = !full;
            tbl_addr = AW'({cnt, 1'b0});
            tbl_data = cur_addr + (half ? HALF_BYTES : 32'h0);
         end
         ST_W1: begin
            tbl_we   = 1'b1;
            tbl_addr = AW'({cnt - CW'(1), 1'b1});
            tbl_data = w1;
         end
         ST_MARK: begin
            // R4: re-write the final count word with the end flag
            tbl_we   = (cnt != '0) && !mode_q;
            tbl_addr = AW'({cnt - CW'(1), 1'b1});
            tbl_data = last_w1 | EOT_FLAG;
         end
         default: ;
      endcase
   end

   assign seg_ready   = (state == ST_SEG) || (state == ST_DRAIN);
   assign done        = (state == ST_DONE);
   assign entry_count = cnt_o;
   assign fallback    = fb_o;
   assign len_err     = err_o;

endmodule

// File: rtl/sg_prd_builder.sv
module sg_prd_builder #(
   parameter int   MAX_DESC = 8,
   parameter int   LEN_W    = 32,
   parameter bit   ALT_EN   = 1'b1,
   localparam int  AW       = (2 * MAX_DESC > 1) ? $clog2(2 * MAX_DESC) : 1,
   localparam int  CW       = $clog2(MAX_DESC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mode_alt,
   input  logic             seg_valid,
   output logic             seg_ready,
   input  logic [31:0]      seg_addr,
   input  logic [LEN_W-1:0] seg_len,
   input  logic             seg_last,
   output logic             tbl_we,
   output logic [AW-1:0]    tbl_addr,
   output logic [31:0]      tbl_data,
   output logic             done,
   output logic [CW-1:0]    entry_count,
   output logic             fallback,
   output logic             len_err
);

   generate
      if (MAX_DESC < 1) begin : g_bad_depth
         $error("MAX_DESC must be at least 1");
      end
      if (LEN_W < 17) begin : g_bad_len
         $error("LEN_W must hold a full 64 KiB piece");
      end
   endgenerate

   logic [16:0]      piece;
   logic             is_final;
   logic [31:0]      w1;
   logic             split_need;
   logic             bad_len;
   logic [15:0]      cur_addr_lo;
   logic [LEN_W-1:0] cur_rem;
   logic             mode_q;

   sgp_piece_calc #(.LEN_W(LEN_W)) u_piece (
      .addr_lo  (cur_addr_lo),
      .rem      (cur_rem),
      .piece    (piece),
      .is_final (is_final)
   );

   sgp_word_fmt #(.ALT_EN(ALT_EN)) u_fmt (
      .alt_req    (mode_q),
      .piece      (piece),
      .len_lo     (seg_len[1:0]),
      .w1         (w1),
      .split_need (split_need),
      .bad_len    (bad_len)
   );

   sgp_ctrl #(
      .MAX_DESC (MAX_DESC),
      .LEN_W    (LEN_W),
      .AW       (AW),
      .CW       (CW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mode_alt    (mode_alt),
      .seg_valid   (seg_valid),
      .seg_addr    (seg_addr),
      .seg_len     (seg_len),
      .seg_last    (seg_last),
      .piece       (piece),
      .is_final    (is_final),
      .w1          (w1),
      .split_need  (split_need),
      .bad_len     (bad_len),
      .seg_ready   (seg_ready),
      .cur_addr_lo (cur_addr_lo),
      .cur_rem     (cur_rem),
      .mode_q      (mode_q),
      .tbl_we      (tbl_we),
      .tbl_addr    (tbl_addr),
      .tbl_data    (tbl_data),
      .done        (done),
      .entry_count (entry_count),
      .fallback    (fallback),
      .len_err     (len_err)
   );

endmodule

// File: rtl/sgp_builder_chk.sv
module sgp_builder_chk #(
   parameter int MAX_DESC = 8,
   parameter int AW       = 4,
   parameter int CW       = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          seg_ready,
   input logic          tbl_we,
   input logic [AW-1:0] tbl_addr,
   input logic [31:0]   tbl_data,
   input logic          done,
   input logic [CW-1:0] entry_count,
   input logic          fallback,
   input logic          len_err,
   input logic          alt_q
);

   // R1
   no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && tbl_addr[0] && !alt_q && $past(tbl_we && !tbl_addr[0]))
      |-> (tbl_data[15:0] != 16'h0) &&
          (({1'b0, $past(tbl_data[15:0])} + {1'b0, tbl_data[15:0]}) <= 17'h10000));

   // R8
   word_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && !tbl_addr[0]) |=> (tbl_we && tbl_addr == $past(tbl_addr) + AW'(1)));

   // R8
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we |-> !seg_ready);

   // R4
   eot_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && tbl_addr[0] && tbl_data[31]) |=> done);

   // R7
   alt_no_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && tbl_addr[0] && alt_q) |-> !tbl_data[31]);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(entry_count) || !$stable(fallback) || !$stable(len_err))
      |-> (done || $past(start)));

   // R5
   fb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fallback) |-> (entry_count == '0));

   // R11
   cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (entry_count <= CW'(MAX_DESC)));

endmodule

bind sg_prd_builder sgp_builder_chk #(
   .MAX_DESC (MAX_DESC),
   .AW       (AW),
   .CW       (CW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .seg_ready   (seg_ready),
   .tbl_we      (tbl_we),
   .tbl_addr    (tbl_addr),
   .tbl_data    (tbl_data),
   .done        (done),
   .entry_count (entry_count),
   .fallback    (fallback),
   .len_err     (len_err),
   .alt_q       (mode_q)
);

// File: tb/sg_prd_builder_tb.sv
`timescale 1ns/1ps
module sg_prd_builder_tb;

   localparam int MAX_DESC = 8;
   localparam int LEN_W    = 32;
   localparam int AW       = 4;
   localparam int CW       = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             mode_alt = 1'b0;
   logic             seg_valid = 1'b0;
   logic             seg_ready;
   logic [31:0]      seg_addr = '0;
   logic [LEN_W-1:0] seg_len = '0;
   logic             seg_last = 1'b0;
   logic             tbl_we;
   logic [AW-1:0]    tbl_addr;
   logic [31:0]      tbl_data;
   logic             done;
   logic [CW-1:0]    entry_count;
   logic             fallback;
   logic             len_err;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sg_prd_builder #(.MAX_DESC(MAX_DESC), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_alt(mode_alt),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
      .seg_len(seg_len), .seg_last(seg_last), .tbl_we(tbl_we),
      .tbl_addr(tbl_addr), .tbl_data(tbl_data), .done(done),
      .entry_count(entry_count), .fallback(fallback), .len_err(len_err)
   );

   // Table image and write bookkeeping, sampled mid-cycle
   logic [31:0] tlog [0:15];
   int          nwr = 0;
   int          rdy_viol = 0;

   always @(negedge clk) begin
      if (tbl_we) begin
         tlog[tbl_addr] <= tbl_data;
         nwr      <= nwr + 1;
         if (seg_ready) rdy_viol <= rdy_viol + 1;
      end
   end

   logic        r_done;
   logic [31:0] r_cnt;
   logic        r_fb;
   logic        r_err;
   logic        r_pulse_ok;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_start(input logic alt);
      @(negedge clk);
      start    = 1'b1;
      mode_alt = alt;
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input logic last);
      @(negedge clk);
      seg_valid = 1'b1;
      seg_addr  = a;
      seg_len   = l;
      seg_last  = last;
      #1;
      while (!seg_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      seg_valid = 1'b0;
   endtask

   task automatic wait_done;
      int n = 0;
      @(negedge clk);
      while (!done && n < 300) begin
         @(negedge clk);
         n++;
      end
      r_done = done;
      r_cnt  = 32'(entry_count);
      r_fb   = fallback;
      r_err  = len_err;
      @(negedge clk);
      r_pulse_ok = !done;
   endtask

   task automatic t_reset;
      chk("R9", "reset done", 32'(done), 0);
      chk("R9", "reset count", 32'(entry_count), 0);
      chk("R9", "reset fallback", 32'(fallback), 0);
      chk("R8", "reset ready", 32'(seg_ready), 0);
      chk("R8", "reset write", 32'(tbl_we), 0);
   endtask

   task automatic t_basic;
      int w0 = nwr;
      do_start(1'b0);
      send_seg(32'h1000_0000, 32'h200, 1'b1);
      wait_done();
      chk("R2", "basic done", 32'(r_done), 1);
      chk("R9", "done width", 32'(r_pulse_ok), 1);
      chk("R2", "basic count", r_cnt, 1);
      chk("R2", "basic word0", tlog[0], 32'h1000_0000);
      chk("R4", "basic word1 marked", tlog[1], 32'h8000_0200);
      chk("R2", "basic writes", 32'(nwr - w0), 3);
      repeat (6) @(negedge clk);
      chk("R9", "count held", 32'(entry_count), 1);
      chk("R9", "fallback held", 32'(fallback), 0);
   endtask

   task automatic t_cross;
      do_start(1'b0);
      chk("R9", "count cleared at start", 32'(entry_count), 0);
      send_seg(32'h0002_FF00, 32'h300, 1'b1);
      wait_done();
      chk("R1", "cross count", r_cnt, 2);
      chk("R1", "cross word0", tlog[0], 32'h0002_FF00);
      chk("R1", "cross word1", tlog[1], 32'h0000_0100);
      chk("R1", "cross word2", tlog[2], 32'h0003_0000);
      chk("R4", "cross word3", tlog[3], 32'h8000_0200);
   endtask

   task automatic t_split;
      do_start(1'b0);
      send_seg(32'h0005_0000, 32'h10000, 1'b1);
      wait_done();
      chk("R3", "split count", r_cnt, 2);
      chk("R3", "split word0", tlog[0], 32'h0005_0000);
      chk("R3", "split word1", tlog[1], 32'h0000_8000);
      chk("R3", "split word2", tlog[2], 32'h0005_8000);
      chk("R3", "split word3", tlog[3], 32'h8000_8000);
   endtask

   task automatic t_multi;
      do_start(1'b0);
      send_seg(32'h0000_1000, 32'h100, 1'b0);
      send_seg(32'h0000_2000, 32'h80, 1'b1);
      wait_done();
      chk("R2", "multi count", r_cnt, 2);
      chk("R4", "multi first unmarked", tlog[1], 32'h0000_0100);
      chk("R2", "multi word2", tlog[2], 32'h0000_2000);
      chk("R4", "multi last marked", tlog[3], 32'h8000_0080);
   endtask

   task automatic t_exact_cap;
      do_start(1'b0);
      send_seg(32'h0000_0000, 32'h40000, 1'b1);
      wait_done();
      chk("R11", "full table fallback", 32'(r_fb), 0);
      chk("R11", "full table count", r_cnt, MAX_DESC);
      chk("R11", "full word14", tlog[14], 32'h0003_8000);
      chk("R4", "full word15", tlog[15], 32'h8000_8000);
   endtask

   task automatic t_overflow;
      do_start(1'b0);
      send_seg(32'h0000_0000, 32'h50000, 1'b1);
      wait_done();
      chk("R5", "overflow fallback", 32'(r_fb), 1);
      chk("R5", "overflow count", r_cnt, 0);
      chk("R5", "overflow no len_err", 32'(r_err), 0);
   endtask

   task automatic t_overflow_half;
      int w0 = nwr;
      do_start(1'b0);
      send_seg(32'h0001_0000, 32'h30000, 1'b0);
      send_seg(32'h0000_0000, 32'h100, 1'b0);
      send_seg(32'h0002_0000, 32'h10000, 1'b1);
      wait_done();
      chk("R5", "half overflow fallback", 32'(r_fb), 1);
      chk("R5", "half overflow count", r_cnt, 0);
      chk("R5", "half overflow writes", 32'(nwr - w0), 16);
   endtask

   task automatic t_empty;
      int w0 = nwr;
      do_start(1'b0);
      send_seg(32'h0000_4000, 32'h0, 1'b0);
      send_seg(32'h0000_8000, 32'h0, 1'b1);
      wait_done();
      chk("R6", "empty done", 32'(r_done), 1);
      chk("R6", "empty fallback", 32'(r_fb), 1);
      chk("R6", "empty count", r_cnt, 0);
      chk("R6", "empty writes", 32'(nwr - w0), 0);
   endtask

   task automatic t_alt;
      int w0 = nwr;
      do_start(1'b1);
      send_seg(32'h0000_1000, 32'h200, 1'b1);
      wait_done();
      chk("R7", "alt count", r_cnt, 1);
      chk("R7", "alt word1", tlog[1], 32'h007F_0000);
      chk("R7", "alt writes no marker", 32'(nwr - w0), 2);
      w0 = nwr;
      do_start(1'b1);
      send_seg(32'h0006_0000, 32'h10000, 1'b1);
      wait_done();
      chk("R7", "alt full count", r_cnt, 1);
      chk("R7", "alt full word0", tlog[0], 32'h0006_0000);
      chk("R7", "alt full word1", tlog[1], 32'h3FFF_0000);
      chk("R7", "alt full writes", 32'(nwr - w0), 2);
   endtask

   task automatic t_bad_len;
      int w0 = nwr;
      do_start(1'b0);
      send_seg(32'h0000_1000, 32'h101, 1'b0);
      send_seg(32'h0000_2000, 32'h100, 1'b1);
      wait_done();
      chk("R10", "odd len_err", 32'(r_err), 1);
      chk("R10", "odd fallback", 32'(r_fb), 1);
      chk("R10", "odd count", r_cnt, 0);
      chk("R10", "odd drained writes", 32'(nwr - w0), 0);
      w0 = nwr;
      do_start(1'b1);
      send_seg(32'h0000_3000, 32'h202, 1'b1);
      wait_done();
      chk("R10", "alt misaligned len_err", 32'(r_err), 1);
      chk("R10", "alt misaligned writes", 32'(nwr - w0), 0);
      do_start(1'b0);
      send_seg(32'h0000_3000, 32'h202, 1'b1);
      wait_done();
      chk("R10", "std even len accepted", 32'(r_err), 0);
      chk("R10", "std even len count", r_cnt, 1);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_basic();
      t_cross();
      t_split();
      t_multi();
      t_exact_cap();
      t_overflow();
      t_overflow_half();
      t_empty();
      t_alt();
      t_bad_len();
      // R8: no segment was accepted while a table word was written
      chk("R8", "ready during writes", 32'(rdy_viol), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule